// File: doc/BRIEF.md
# 64-bit Snapshot Counter with Torn-Read Detection

This block is a free-running cycle counter, 64 bits wide by default. A processor with a 32-bit register bus can only read it one half at a time. If the counter moves between the two accesses, the two halves may not describe the same instant. A small sequence tracker watches the bus for a read of the low half followed by a read of the high half. It notes two kinds of disturbance in between: a carry out of the low half into the high half, and a pulse on the interrupt-taken input. It publishes the verdict in the top bit of the control register.

Software reads the low half, then the high half, then the control register. It repeats the three reads until the verdict bit is 1. The counter starts disabled after reset and counts one step per clock once bit 0 of the control register is written with 1.

Top module: `snapcnt_top`

## Requirements
- R1: After reset the count is zero, counting is disabled, and the verdict bit reads 0.
- R2: A write to the control address (0x103) loads the enable flag from data bit 0. A read of the control address returns the enable flag in bit 0, the verdict in bit 31, and zeros in all other bits.
- R3: While enabled, the count rises by exactly one per clock. While disabled, it holds its value.
- R4: The count wraps from all ones to zero.
- R5: A read returns its data with `rd_valid` high on the cycle after the request. The low half is at 0x104 and the high half at 0x105, each zero-extended to the bus width. Reads of any other address return zero. Writes to the two count addresses have no effect.
- R6: A low-half read arms the tracker and sets a provisional-good flag. A later high-half read then sets the verdict to 1 if nothing disturbed the sequence.
- R7: An interrupt-taken pulse in any cycle from the low-half read up to, but not including, the high-half read makes the verdict 0.
- R8: A carry into the high half in any cycle from the low-half read up to, but not including, the high-half read makes the verdict 0. A carry in the same cycle as the high-half read does not.
- R9: A high-half read that is not preceded by a low-half read since the last high-half read sets the verdict to 0.
- R10: The verdict holds its value until the next low-half read, which clears it to 0. Interrupt pulses and control reads do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | BUS_W | Write data |
| irq_taken | input | 1 | Pulse marking that the processor took an interrupt or exception |
| rd_data | output | BUS_W | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a read result |

## Verification
The bench runs with a 16-bit count, so a carry out of the low half comes every 256 cycles and a full wrap fits in the run. Low/high/control sequences are tried in several forms:
- an undisturbed sequence, which must give a good verdict;
- an interrupt pulse between the reads, which separates R7 from R6;
- a low read placed two cycles before a carry, which must be flagged;
- a carry landing exactly on the high read, which must not be flagged (this pins the window edge of R8);
- a lone high read, which separates R9 from a stale verdict.

Enable and disable, writes to the read-only halves, unmapped reads and the full wrap of the count are compared against a cycle-level model kept in the bench.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;

  // Register selected by one bus access.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LOW  = 2'd2,
    SEL_HIGH = 2'd3
  } reg_sel_e;

  // Bit holding the enable flag in the control register.
  localparam int unsigned ENABLE_BIT = 0;

endpackage

// File: rtl/snapcnt_decode.sv
module snapcnt_decode
  import snapcnt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              rd_any,
  output logic              low_rd,
  output logic              high_rd,
  output logic              ctrl_wr
);

  always_comb begin
    if (bus_addr == CTRL_ADDR)      sel = SEL_CTRL;
    else if (bus_addr == LOW_ADDR)  sel = SEL_LOW;
    else if (bus_addr == HIGH_ADDR) sel = SEL_HIGH;
    else                            sel = SEL_NONE;
  end

  assign rd_any  = bus_en && !bus_we;
  assign low_rd  = rd_any && (sel == SEL_LOW);
  assign high_rd = rd_any && (sel == SEL_HIGH);
  assign ctrl_wr = bus_en && bus_we && (sel == SEL_CTRL);

endmodule

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
  parameter int unsigned CNT_W  = 64,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  output logic [HALF_W-1:0] low_q,
  output logic [HALF_W-1:0] high_q,
  output logic              carry
);

  // Carry out of the low half at the coming edge.
  assign carry = enable && (low_q == {HALF_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (enable) begin
      low_q <= low_q + 1'b1;
      if (carry) high_q <= high_q + 1'b1;
    end
  end

endmodule

// File: rtl/snapcnt_tracker.sv
module snapcnt_tracker (
  input  logic clk,
  input  logic rst,
  input  logic low_rd,
  input  logic high_rd,
  input  logic carry,
  input  logic irq_taken,
  output logic armed,
  output logic prov_good,
  output logic verdict
);

  logic disturb;
  assign disturb = carry || irq_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      prov_good <= 1'b0;
      verdict   <= 1'b0;
    end else if (low_rd) begin
      armed     <= 1'b1;
      prov_good <= !disturb;
      verdict   <= 1'b0;
    end else if (high_rd) begin
      armed     <= 1'b0;
      prov_good <= 1'b0;
      verdict   <= armed && prov_good;
    end else if (armed && disturb) begin
      prov_good <= 1'b0;
    end
  end

endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              irq_taken,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);

  localparam int unsigned HALF_W   = CNT_W / 2;
  localparam int unsigned VERDICT_BIT = BUS_W - 1;

  reg_sel_e          sel;
  logic              rd_any, low_rd, high_rd, ctrl_wr;
  logic              en_q, carry, armed, prov_good, verdict;
  logic [HALF_W-1:0] low_q, high_q;
  logic [CNT_W-1:0]  count;
  logic [BUS_W-1:0]  ctrl_word, rd_next;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[BUS_W-1:1];
  assign count = {high_q, low_q};

  snapcnt_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
  ) u_decode (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .sel(sel), .rd_any(rd_any), .low_rd(low_rd),
    .high_rd(high_rd), .ctrl_wr(ctrl_wr)
  );

  snapcnt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .enable(en_q),
    .low_q(low_q), .high_q(high_q), .carry(carry)
  );

  snapcnt_tracker u_tracker (
    .clk(clk), .rst(rst), .low_rd(low_rd), .high_rd(high_rd),
    .carry(carry), .irq_taken(irq_taken),
    .armed(armed), .prov_good(prov_good), .verdict(verdict)
  );

  // Control register: enable flag.
  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (ctrl_wr) en_q <= bus_wdata[ENABLE_BIT];
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[ENABLE_BIT]  = en_q;
    ctrl_word[VERDICT_BIT] = verdict;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_next = ctrl_word;
      SEL_LOW:  rd_next = BUS_W'(low_q);
      SEL_HIGH: rd_next = BUS_W'(high_q);
      default:  rd_next = '0;
    endcase
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_any;
      if (rd_any) rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/snapcnt_chk.sv
module snapcnt_chk #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 12'h104,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h105,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_taken,
  input logic              en_q,
  input logic [CNT_W-1:0]  count,
  input logic              armed,
  input logic              prov_good,
  input logic              verdict,
  input logic              rd_valid
);

  logic lo_r, hi_r, wrap_carry;
  assign lo_r = bus_en && !bus_we && (bus_addr == LOW_ADDR);
  assign hi_r = bus_en && !bus_we && (bus_addr == HIGH_ADDR);
  assign wrap_carry = en_q && (count[HALF_W-1:0] == {HALF_W{1'b1}});

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(rst)) |-> count == $past(count) + 1'b1);

  p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(en_q) && !$past(rst)) |-> $stable(count));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(rst) && $past(count) == {CNT_W{1'b1}}) |-> count == '0);

  p_read_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we) |=> rd_valid);

  p_prov_needs_arm_r6: assert property (@(posedge clk) disable iff (rst)
    prov_good |-> armed);

  p_irq_spoils_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && irq_taken) |=> !prov_good);

  p_carry_spoils_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && wrap_carry) |=> !prov_good);

  p_orphan_high_r9: assert property (@(posedge clk) disable iff (rst)
    (hi_r && !armed) |=> !verdict);

  p_verdict_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!lo_r && !hi_r) |=> verdict == $past(verdict));

  p_low_clears_r10: assert property (@(posedge clk) disable iff (rst)
    lo_r |=> !verdict);

endmodule

bind snapcnt_top snapcnt_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq_taken(irq_taken), .en_q(en_q), .count(count), .armed(armed),
  .prov_good(prov_good), .verdict(verdict), .rd_valid(rd_valid)
);

// File: tb/snapcnt_top_test.sv
module snapcnt_top_test;
  localparam int CW = 16;
  localparam int H  = CW / 2;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LOW  = 12'h104;
  localparam logic [11:0] A_HIGH = 12'h105;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0, irq_taken = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid;

  always #5 clk = ~clk;

  snapcnt_top #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_taken(irq_taken),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Reference model built from the requirements.
  logic [CW-1:0] mcnt;
  logic men, marm, mprov, mstat, mcarry, mdist, mlo, mhi;
  always @(posedge clk) begin
    if (rst) begin
      mcnt <= '0; men <= 1'b0; marm <= 1'b0; mprov <= 1'b0; mstat <= 1'b0;
    end else begin
      mcarry = men && (mcnt[H-1:0] == {H{1'b1}});
      mdist  = mcarry || irq_taken;
      mlo    = bus_en && !bus_we && bus_addr == A_LOW;
      mhi    = bus_en && !bus_we && bus_addr == A_HIGH;
      if (men) mcnt <= mcnt + 1'b1;
      if (bus_en && bus_we && bus_addr == A_CTRL) men <= bus_wdata[0];
      if (mlo) begin marm <= 1'b1; mprov <= !mdist; mstat <= 1'b0; end
      else if (mhi) begin marm <= 1'b0; mprov <= 1'b0; mstat <= marm && mprov; end
      else if (marm && mdist) mprov <= 1'b0;
    end
  end

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] expect_for(logic [11:0] a);
    case (a)
      A_CTRL:  return {mstat, 30'b0, men};
      A_LOW:   return 32'(mcnt[H-1:0]);
      A_HIGH:  return 32'(mcnt[CW-1:H]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(expect_for(a)); tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic irq_pulse();
    @(negedge clk); irq_taken = 1'b1;
    @(negedge clk); irq_taken = 1'b0;
  endtask

  task automatic wait_low(input logic [H-1:0] v);
    while (mcnt[H-1:0] != v) @(negedge clk);
  endtask

  // Monitor: compare every read result against the scoreboard.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read result got %h exp none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s got %h exp %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got hang exp finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, counter idle before enable
    rd(A_CTRL, "R1 ctrl after reset");
    rd(A_LOW,  "R1 low after reset");
    rd(A_HIGH, "R1 high after reset");
    // R2: enable and read back the flag
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, "R2 enable flag");
    // R3: counting, clean snapshot for R6
    rd(A_LOW,  "R3 low counting");
    rd(A_HIGH, "R3 high counting");
    rd(A_CTRL, "R6 clean pair verdict");
    // R10: verdict held across irq and control reads
    irq_pulse();
    rd(A_CTRL, "R10 verdict held after irq");
    // R10: a low read clears the verdict
    rd(A_LOW,  "R10 low read");
    rd(A_CTRL, "R10 verdict cleared by low read");
    // R7: interrupt between the reads
    rd(A_HIGH, "R7 high closes pending pair");
    rd(A_LOW,  "R7 low");
    irq_pulse();
    rd(A_HIGH, "R7 high");
    rd(A_CTRL, "R7 torn by irq");
    // R9: high read with no low read
    rd(A_LOW,  "R9 setup low");
    rd(A_HIGH, "R9 setup high");
    rd(A_HIGH, "R9 lone high");
    rd(A_CTRL, "R9 verdict zero");
    // R8: carry between the reads
    wait_low(8'hFD);
    rd(A_LOW,  "R8 low before carry");
    rd(A_HIGH, "R8 high after carry");
    rd(A_CTRL, "R8 torn by carry");
    // R8: carry on the high read cycle is not torn
    wait_low(8'hFC);
    rd(A_LOW,  "R8 low edge case");
    rd(A_HIGH, "R8 high on carry cycle");
    rd(A_CTRL, "R8 carry on high read ok");
    // R5: writes to count halves ignored, unmapped reads zero
    wr(A_LOW, 32'hFFFF_FFFF);
    wr(A_HIGH, 32'hFFFF_FFFF);
    rd(A_LOW,  "R5 low after ignored write");
    rd(A_HIGH, "R5 high after ignored write");
    rd(12'h106, "R5 unmapped read");
    // R4: full wrap of the count
    while (mcnt != 16'hFFFE) @(negedge clk);
    rd(A_LOW,  "R4 low at all ones");
    rd(A_HIGH, "R4 high after wrap");
    rd(A_CTRL, "R4 wrap carry flagged");
    // R2/R3: disable holds the count
    wr(A_CTRL, 32'h0);
    rd(A_LOW,  "R3 low disabled");
    repeat (5) @(negedge clk);
    rd(A_LOW,  "R3 low still held");
    rd(A_CTRL, "R2 disabled flag");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 pending reads got %0d exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule